// File: doc/BRIEF.md
# Physical register wakeup scoreboard

This block keeps one valid bit per physical register and tracks which issue queue entries still wait on which registers. Rename announces each new producer through the allocation port. That clears the register's bit until the producer completes. The insert port places a consumer into a queue entry. At insert time the block checks every source that rename did not already mark ready against the scoreboard. A source whose register is still pending is recorded as a bit in a wakeup matrix, with one row per queue entry and one column per physical register.

The completion port broadcasts one destination tag per cycle. It sets that register's valid bit and clears the column in every row, so all consumers waiting on the register wake together. Each entry drives a ready line toward the issue queue. The line is high while the entry is occupied and has no outstanding wait bit, and it rises combinationally in the cycle of the completion that removes the last wait bit. Tags at or above the tracked register count name registers that are never renamed. Such tags are not tracked and do not affect any port.

Top module: `preg_wakeup_sb`

## Requirements
- R1: While reset is asserted and after it is released, every scoreboard bit (`reg_ready_o`) is 0, every `entry_ready_o` bit is 0 and `alloc_err_o` is 0.
- R2: An allocation of an in-range tag clears that register's scoreboard bit from the next cycle. When an allocation and a completion name the same register in one cycle, the bit ends up clear.
- R3: A completion of an in-range tag sets that register's scoreboard bit from the next cycle.
- R4: An insert occupies the entry `ins_idx_i`. Source s uses the tag bits `ins_tag_i[s*TAG_W +: TAG_W]` and the flag `ins_rdy_i[s]`. If no source is still pending, the entry's ready line is high from the cycle after the insert.
- R5: A waiting entry raises its ready line in the same cycle as the completion that clears its last pending source. The line then stays high until the entry is squashed or overwritten.
- R6: One completion wakes every entry waiting on that register. An entry waiting on two different registers stays not ready until both have completed.
- R7: A tag at or above the tracked register count (INT_REGS+FP_REGS) is ignored. Allocating or completing such a tag changes no scoreboard bit and no ready line. Such a tag used as a source counts as ready.
- R8: `alloc_err_o` is high in a cycle where an allocation names a register on which some entry is still waiting. It is low in every other cycle.
- R9: A set bit in `sq_mask_i` frees that entry and drops its wait registrations. From the next cycle its ready line is low. It no longer causes an allocation error, and a later completion does not wake it. An insert to the same entry in the same cycle takes precedence over the squash.
- R10: A completion in the same cycle as an insert that names the same register as a source counts that source as ready, so no wakeup is lost.
- R11: A source with its `ins_rdy_i` flag set is not checked against the scoreboard and never waits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | A producer is allocated this cycle |
| alloc_tag_i | input | TAG_W | Destination register of the allocated producer |
| ins_valid_i | input | 1 | A consumer is inserted this cycle |
| ins_idx_i | input | IDX_W | Queue entry being written |
| ins_tag_i | input | NUM_SRCS*TAG_W | Source register tags; source s is at [s*TAG_W +: TAG_W] |
| ins_rdy_i | input | NUM_SRCS | Per-source ready flag supplied by rename |
| cmp_valid_i | input | 1 | A producer completes this cycle |
| cmp_tag_i | input | TAG_W | Destination register of the completing producer |
| sq_mask_i | input | ENTRIES | Entries to squash this cycle |
| reg_ready_o | output | INT_REGS+FP_REGS | Scoreboard valid bit per tracked register |
| entry_ready_o | output | ENTRIES | Entry is occupied and all of its sources are ready |
| alloc_err_o | output | 1 | Allocation names a register that still has waiting consumers |

## Verification
Two functions can act in the same cycle: a completion and an insert whose source names the completing register. The bench drives both in one cycle on a register whose scoreboard bit is clear. It then requires the entry to be ready in the following cycle, and it requires a later allocation of that register to raise no error, which shows that no stale wait bit was left behind. The bench also checks the combinational wakeup path. It drives a completion that clears an entry's last pending source and reads the ready line before the clock edge, while a second entry still waiting on another register must stay low.

// File: rtl/preg_wk_pkg.sv
package preg_wk_pkg;
  localparam int unsigned DEF_INT_REGS = 24;
  localparam int unsigned DEF_FP_REGS  = 16;
  localparam int unsigned DEF_TAG_W    = 6;
  localparam int unsigned DEF_ENTRIES  = 8;
  localparam int unsigned DEF_SRCS     = 2;
endpackage

// File: rtl/wk_tag_dec.sv
module wk_tag_dec #(
  parameter int unsigned NPREGS = 40,
  parameter int unsigned TAG_W  = 6
) (
  input  logic              valid_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic [NPREGS-1:0] oh_o
);
  // tags >= NPREGS match no column and fall out as all-zero
  for (genvar r = 0; r < NPREGS; r++) begin : g_col
    assign oh_o[r] = valid_i && (tag_i == TAG_W'(r));
  end
endmodule

// File: rtl/wk_scoreboard.sv
module wk_scoreboard #(
  parameter int unsigned NPREGS = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPREGS-1:0] set_i,
  input  logic [NPREGS-1:0] clr_i,
  output logic [NPREGS-1:0] bits_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_o <= '0;
    else         bits_o <= (bits_o | set_i) & ~clr_i;  // allocation wins
  end
endmodule

// File: rtl/wk_row.sv
module wk_row #(
  parameter int unsigned NPREGS = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ins_i,
  input  logic              sq_i,
  input  logic [NPREGS-1:0] wait_i,
  input  logic [NPREGS-1:0] wake_i,
  output logic              ready_o,
  output logic [NPREGS-1:0] wait_o
);
  logic occ_q;
  logic [NPREGS-1:0] wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q  <= 1'b0;
      wait_q <= '0;
    end else if (ins_i) begin
      occ_q  <= 1'b1;
      wait_q <= wait_i;
    end else if (sq_i) begin
      occ_q  <= 1'b0;
      wait_q <= '0;
    end else begin
      wait_q <= wait_q & ~wake_i;
    end
  end

  // same-cycle wakeup: mask bits being cleared this cycle
  assign ready_o = occ_q && ~|(wait_q & ~wake_i);
  assign wait_o  = wait_q;
endmodule

// File: rtl/preg_wakeup_sb.sv
module preg_wakeup_sb #(
  parameter int unsigned INT_REGS = preg_wk_pkg::DEF_INT_REGS,
  parameter int unsigned FP_REGS  = preg_wk_pkg::DEF_FP_REGS,
  parameter int unsigned TAG_W    = preg_wk_pkg::DEF_TAG_W,
  parameter int unsigned ENTRIES  = preg_wk_pkg::DEF_ENTRIES,
  parameter int unsigned NUM_SRCS = preg_wk_pkg::DEF_SRCS,
  localparam int unsigned NPREGS  = INT_REGS + FP_REGS,
  localparam int unsigned IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      alloc_valid_i,
  input  logic [TAG_W-1:0]          alloc_tag_i,
  input  logic                      ins_valid_i,
  input  logic [IDX_W-1:0]          ins_idx_i,
  input  logic [NUM_SRCS*TAG_W-1:0] ins_tag_i,
  input  logic [NUM_SRCS-1:0]       ins_rdy_i,
  input  logic                      cmp_valid_i,
  input  logic [TAG_W-1:0]          cmp_tag_i,
  input  logic [ENTRIES-1:0]        sq_mask_i,
  output logic [NPREGS-1:0]         reg_ready_o,
  output logic [ENTRIES-1:0]        entry_ready_o,
  output logic                      alloc_err_o
);
  logic [NPREGS-1:0] alloc_oh, cmp_oh, ins_wait, col_wait;
  logic [NPREGS-1:0] src_oh  [NUM_SRCS];
  logic [NPREGS-1:0] row_wait[ENTRIES];

  wk_tag_dec #(.NPREGS(NPREGS), .TAG_W(TAG_W)) u_alloc_dec (
    .valid_i(alloc_valid_i), .tag_i(alloc_tag_i), .oh_o(alloc_oh));
  wk_tag_dec #(.NPREGS(NPREGS), .TAG_W(TAG_W)) u_cmp_dec (
    .valid_i(cmp_valid_i), .tag_i(cmp_tag_i), .oh_o(cmp_oh));

  // sources flagged ready by rename are never decoded
  for (genvar s = 0; s < NUM_SRCS; s++) begin : g_src
    wk_tag_dec #(.NPREGS(NPREGS), .TAG_W(TAG_W)) u_src_dec (
      .valid_i(ins_valid_i && !ins_rdy_i[s]),
      .tag_i  (ins_tag_i[s*TAG_W +: TAG_W]),
      .oh_o   (src_oh[s]));
  end

  // scoreboard check at insert, with a same-cycle completion bypass
  always_comb begin
    ins_wait = '0;
    for (int s = 0; s < NUM_SRCS; s++) ins_wait |= src_oh[s];
    ins_wait &= ~reg_ready_o & ~cmp_oh;
  end

  wk_scoreboard #(.NPREGS(NPREGS)) u_sb (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(cmp_oh), .clr_i(alloc_oh), .bits_o(reg_ready_o));

  for (genvar e = 0; e < ENTRIES; e++) begin : g_row
    wk_row #(.NPREGS(NPREGS)) u_row (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ins_i  (ins_valid_i && (ins_idx_i == IDX_W'(e))),
      .sq_i   (sq_mask_i[e]),
      .wait_i (ins_wait),
      .wake_i (cmp_oh),
      .ready_o(entry_ready_o[e]),
      .wait_o (row_wait[e]));
  end

  always_comb begin
    col_wait = '0;
    for (int e = 0; e < ENTRIES; e++) col_wait |= row_wait[e];
  end

  assign alloc_err_o = |(alloc_oh & col_wait);
endmodule

// File: rtl/wk_chk.sv
module wk_chk #(
  parameter int unsigned NPREGS  = 40,
  parameter int unsigned TAG_W   = 6,
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned IDX_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               alloc_valid_i,
  input logic [TAG_W-1:0]   alloc_tag_i,
  input logic               ins_valid_i,
  input logic [IDX_W-1:0]   ins_idx_i,
  input logic               cmp_valid_i,
  input logic [TAG_W-1:0]   cmp_tag_i,
  input logic [ENTRIES-1:0] sq_mask_i,
  input logic [NPREGS-1:0]  reg_ready_o,
  input logic [ENTRIES-1:0] entry_ready_o,
  input logic               alloc_err_o
);
  localparam logic [TAG_W:0] LIM = (TAG_W+1)'(NPREGS);
  logic alloc_in, cmp_in;
  assign alloc_in = alloc_valid_i && ({1'b0, alloc_tag_i} < LIM);
  assign cmp_in   = cmp_valid_i && ({1'b0, cmp_tag_i} < LIM);

  // R2
  alloc_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_in |=> !reg_ready_o[$past(alloc_tag_i)]);

  // R3
  cmp_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_in && !(alloc_valid_i && alloc_tag_i == cmp_tag_i))
      |=> reg_ready_o[$past(cmp_tag_i)]);

  // R7
  out_of_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alloc_in && !cmp_in) |=> $stable(reg_ready_o));

  // R8
  err_needs_alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_err_o |-> alloc_in);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic ins_hit;
    assign ins_hit = ins_valid_i && (ins_idx_i == IDX_W'(e));

    // R5
    ready_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (entry_ready_o[e] && !sq_mask_i[e] && !ins_hit) |=> entry_ready_o[e]);

    // R9
    squash_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sq_mask_i[e] && !ins_hit) |=> !entry_ready_o[e]);
  end
endmodule

bind preg_wakeup_sb wk_chk #(
  .NPREGS(NPREGS), .TAG_W(TAG_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .alloc_valid_i(alloc_valid_i), .alloc_tag_i(alloc_tag_i),
  .ins_valid_i(ins_valid_i), .ins_idx_i(ins_idx_i),
  .cmp_valid_i(cmp_valid_i), .cmp_tag_i(cmp_tag_i),
  .sq_mask_i(sq_mask_i), .reg_ready_o(reg_ready_o),
  .entry_ready_o(entry_ready_o), .alloc_err_o(alloc_err_o));

// File: tb/sim_preg_wakeup_sb.sv
module sim_preg_wakeup_sb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 40;
  localparam int TW = 6;
  localparam int NE = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic alloc_valid_i, ins_valid_i, cmp_valid_i;
  logic [TW-1:0] alloc_tag_i, cmp_tag_i;
  logic [2:0] ins_idx_i;
  logic [2*TW-1:0] ins_tag_i;
  logic [1:0] ins_rdy_i;
  logic [NE-1:0] sq_mask_i;
  logic [NP-1:0] reg_ready_o;
  logic [NE-1:0] entry_ready_o;
  logic alloc_err_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  preg_wakeup_sb u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .alloc_valid_i(alloc_valid_i), .alloc_tag_i(alloc_tag_i),
    .ins_valid_i(ins_valid_i), .ins_idx_i(ins_idx_i),
    .ins_tag_i(ins_tag_i), .ins_rdy_i(ins_rdy_i),
    .cmp_valid_i(cmp_valid_i), .cmp_tag_i(cmp_tag_i),
    .sq_mask_i(sq_mask_i), .reg_ready_o(reg_ready_o),
    .entry_ready_o(entry_ready_o), .alloc_err_o(alloc_err_o));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    alloc_valid_i = 0; alloc_tag_i = '0;
    ins_valid_i = 0; ins_idx_i = '0; ins_tag_i = '0; ins_rdy_i = '0;
    cmp_valid_i = 0; cmp_tag_i = '0; sq_mask_i = '0;
  endtask

  task automatic cyc();
    @(negedge clk_i);
    idle();
    #1;
  endtask

  task automatic set_ins(int idx, int t0, int t1, logic [1:0] rdy);
    ins_valid_i = 1; ins_idx_i = 3'(idx);
    ins_tag_i = {TW'(t1), TW'(t0)}; ins_rdy_i = rdy;
  endtask

  task automatic set_alloc(int t); alloc_valid_i = 1; alloc_tag_i = TW'(t); endtask
  task automatic set_cmp(int t);   cmp_valid_i = 1;   cmp_tag_i = TW'(t);   endtask

  task automatic t_reset();
    idle();
    repeat (2) @(negedge clk_i);
    chk("R1 sb in reset", 64'(reg_ready_o), 0);
    chk("R1 ready in reset", 64'(entry_ready_o), 0);
    chk("R1 err in reset", 64'(alloc_err_o), 0);
    rst_ni = 1'b1;
    cyc();
    chk("R1 sb after reset", 64'(reg_ready_o), 0);
    chk("R1 ready after reset", 64'(entry_ready_o), 0);
  endtask

  task automatic t_alloc_cmp();
    set_cmp(5); cyc();
    chk("R3 cmp sets bit", 64'(reg_ready_o[5]), 1);
    set_alloc(5); cyc();
    chk("R2 alloc clears bit", 64'(reg_ready_o[5]), 0);
    set_cmp(6); cyc();
    chk("R3 cmp sets bit 6", 64'(reg_ready_o[6]), 1);
    set_alloc(6); set_cmp(6); cyc();
    chk("R2 alloc wins over cmp", 64'(reg_ready_o[6]), 0);
  endtask

  task automatic t_insert_ready();
    set_cmp(3); cyc();
    set_ins(0, 3, 7, 2'b10);
    #1 chk("R4 not ready before insert", 64'(entry_ready_o[0]), 0);
    cyc();
    chk("R11 R4 ready after insert", 64'(entry_ready_o[0]), 1);
  endtask

  task automatic t_wait_wake();
    set_ins(1, 10, 11, 2'b00); cyc();
    set_ins(2, 10, 10, 2'b00); cyc();
    set_ins(3, 11, 12, 2'b00); cyc();
    chk("R5 waiting entries low", 64'(entry_ready_o[3:1]), 0);
    set_cmp(10);
    #1 chk("R5 same-cycle wake", 64'(entry_ready_o[2]), 1);
    chk("R6 partial wake stays low", 64'(entry_ready_o[1]), 0);
    cyc();
    chk("R5 ready holds", 64'(entry_ready_o[3:1]), 64'(3'b010));
    set_cmp(11);
    #1 chk("R6 second source wakes", 64'(entry_ready_o[3:1]), 64'(3'b011));
    cyc();
    set_cmp(12); cyc();
    chk("R6 all woken", 64'(entry_ready_o[3:1]), 64'(3'b111));
  endtask

  task automatic t_out_of_range();
    logic [NP-1:0] sb0;
    logic [NE-1:0] rd0;
    sb0 = reg_ready_o; rd0 = entry_ready_o;
    set_alloc(45); cyc();
    chk("R7 alloc oor no effect", 64'(reg_ready_o), 64'(sb0));
    set_cmp(63); cyc();
    chk("R7 cmp oor sb", 64'(reg_ready_o), 64'(sb0));
    chk("R7 cmp oor entries", 64'(entry_ready_o), 64'(rd0));
    set_ins(4, 50, 3, 2'b00); cyc();
    chk("R7 oor source ready", 64'(entry_ready_o[4]), 1);
  endtask

  task automatic t_alloc_err();
    set_ins(5, 20, 20, 2'b00); cyc();
    set_alloc(20);
    #1 chk("R8 err with waiter", 64'(alloc_err_o), 1);
    cyc();
    chk("R8 err low idle", 64'(alloc_err_o), 0);
    set_alloc(21);
    #1 chk("R8 no waiter", 64'(alloc_err_o), 0);
    cyc();
    set_cmp(20); cyc();
    chk("R6 entry5 woken", 64'(entry_ready_o[5]), 1);
    set_alloc(20);
    #1 chk("R8 after wake", 64'(alloc_err_o), 0);
    cyc();
  endtask

  task automatic t_squash();
    set_ins(6, 25, 25, 2'b00); cyc();
    set_alloc(25);
    #1 chk("R8 err before squash", 64'(alloc_err_o), 1);
    cyc();
    sq_mask_i = 8'h41; cyc();
    chk("R9 squashed entries low", 64'(entry_ready_o & 8'h41), 0);
    set_alloc(25);
    #1 chk("R9 registration gone", 64'(alloc_err_o), 0);
    cyc();
    set_cmp(25); cyc();
    chk("R9 no wake after squash", 64'(entry_ready_o[6]), 0);
    sq_mask_i = 8'h40; set_ins(6, 3, 3, 2'b00); cyc();
    chk("R9 insert beats squash", 64'(entry_ready_o[6]), 1);
  endtask

  task automatic t_same_cycle();
    set_alloc(30); cyc();
    set_ins(7, 30, 30, 2'b00); set_cmp(30); cyc();
    chk("R10 ready after bypass", 64'(entry_ready_o[7]), 1);
    set_alloc(30);
    #1 chk("R10 no stale wait", 64'(alloc_err_o), 0);
    cyc();
  endtask

  initial begin
    t_reset();
    t_alloc_cmp();
    t_insert_ready();
    t_wait_wake();
    t_out_of_range();
    t_alloc_err();
    t_squash();
    t_same_cycle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule